// File: doc/BRIEF.md
# Cache Fill Auto-Prefetch Generator

This block sits beside a data cache controller and watches the line fills that the controller issues. For every accepted fill it decides whether a neighbouring 32-byte line should also be fetched. If it should, the block computes that line's address and places a prefetch request on a valid/ready output. The decision follows a two-bit policy field and a global enable. Each request also carries the way mask that the replacement logic must respect when it allocates the prefetched line.

Two lock masks are supplied. A fill raised by an ordinary instruction gets the auto-prefetch lock mask. A fill raised by an instruction that uses the restricted-cache prefix gets the prefix lock mask instead. A single-entry output register holds the request until the consumer takes it. While that register is occupied and not draining, the fill input is held off, so no prefetch is ever dropped. The enable, policy and masks are sampled when a fill is accepted.

Top module: `apf_gen`

## Requirements
- R1: When `cfg_enable` is 0 at fill acceptance, no prefetch request follows that fill, whatever `cfg_mode` holds.
- R2: With `cfg_mode` = 2'b00, a fill whose address bit 5 is 0 yields a prefetch to the same address with bit 5 set. A fill whose address bit 5 is 1 yields nothing. For example, fill 0h gives prefetch 20h.
- R3: With `cfg_mode` = 2'b01, every fill yields a prefetch to the fill address with bit 5 inverted.
- R4: With `cfg_mode` = 2'b10 or 2'b11, a fill yields a prefetch to the fill line plus one 32-byte line. When fill address bits [11:5] are all ones, no prefetch is issued.
- R5: Every prefetch address has bits [4:0] equal to 0. Every bit above bit 11 is copied unchanged from the fill address.
- R6: `pf_way_mask` equals `cfg_apf_lock` when `fill_prefix` was 0 at acceptance, and equals `cfg_pfx_lock` when it was 1.
- R7: A prefetch appears on `pf_valid` in the cycle after its fill is accepted. Its address and mask stay stable until a cycle with `pf_ready` high.
- R8: `fill_ready` is low exactly while a prefetch is pending and `pf_ready` is low. A fill accepted in the same cycle that the pending prefetch is taken replaces it without loss.
- R9: Changes to `cfg_*` inputs after a fill is accepted do not alter the prefetch that fill produced.
- R10: After reset, `pf_valid` is 0 and `fill_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | A line fill is being reported |
| fill_ready | output | 1 | Block can accept a fill this cycle |
| fill_addr | input | ADDR_W | Byte address of the filled line |
| fill_prefix | input | 1 | Fill came from a restricted-prefix instruction |
| cfg_enable | input | 1 | Auto-prefetch enable |
| cfg_mode | input | 2 | Prefetch policy: 00 even-only, 01 pair toggle, 1x next line |
| cfg_apf_lock | input | WAYS | Ways locked for ordinary-instruction prefetches |
| cfg_pfx_lock | input | WAYS | Ways locked for restricted-prefix prefetches |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer takes the request this cycle |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_way_mask | output | WAYS | Way mask that replacement must honour |

## Verification
Two functions can meet in one cycle: the pending prefetch is taken by the consumer while a new fill is accepted and loads the output register. The bench first holds `pf_ready` low so that a prefetch waits, and checks that the fill input stalls and the pending request stays unchanged while the configuration and fill address change. It then raises `pf_ready` with a fill already waiting, and expects the next cycle to show the new fill's prefetch, computed under the new configuration, with no gap and no repeat of the old request.

// File: rtl/apf_pkg.sv
// Package: shared definitions for the auto-prefetch generator.
// Assumes 32-byte lines and 4 KB pages unless the top overrides the bit positions.
package apf_pkg;

    // Policy encodings carried on cfg_mode.
    typedef enum logic [1:0] {
        APF_EVEN_ONLY = 2'b00,
        APF_PAIR      = 2'b01,
        APF_NEXT      = 2'b10,
        APF_NEXT_ALT  = 2'b11
    } apf_mode_e;

    localparam int unsigned APF_LINE_LSB_DEF = 5;
    localparam int unsigned APF_PAGE_LSB_DEF = 12;

endpackage

// File: rtl/apf_policy.sv
// Module: apf_policy
// Purely combinational decision. Given the enable, the policy and the fill
// address, it says whether a prefetch is wanted and which line it targets.
// Assumes LINE_LSB < PAGE_LSB < ADDR_W. Bits below LINE_LSB never reach the
// output, and bits from PAGE_LSB upward are copied through.
module apf_policy
    import apf_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LINE_LSB = APF_LINE_LSB_DEF,
    parameter int unsigned PAGE_LSB = APF_PAGE_LSB_DEF
) (
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              issue,
    output logic [ADDR_W-1:0] target
);

    localparam int unsigned IDX_W = PAGE_LSB - LINE_LSB;
    localparam logic [ADDR_W-1:0] OFS_MASK = (ADDR_W'(1) << LINE_LSB) - ADDR_W'(1);
    localparam logic [IDX_W-1:0]  IDX_LAST = '1;

    logic [ADDR_W-1:0] line_base;
    logic [IDX_W-1:0]  line_idx;
    logic [IDX_W-1:0]  line_idx_next;
    logic              odd_line;
    logic              page_end;
    apf_mode_e         pol;

    // Split the fill address into its line base, in-page index and parity.
    always_comb begin
        line_base     = fill_addr & ~OFS_MASK;
        line_idx      = line_base[PAGE_LSB-1:LINE_LSB];
        line_idx_next = line_idx + IDX_W'(1);
        odd_line      = line_base[LINE_LSB];
        page_end      = (line_idx == IDX_LAST);
        pol           = apf_mode_e'(mode);
    end

    // Pick the prefetch line and decide whether it is issued under the policy.
    always_comb begin
        issue  = 1'b0;
        target = line_base;
        unique case (pol)
            APF_EVEN_ONLY: begin
                issue            = enable && !odd_line;
                target[LINE_LSB] = 1'b1;
            end
            APF_PAIR: begin
                issue            = enable;
                target[LINE_LSB] = ~odd_line;
            end
            APF_NEXT, APF_NEXT_ALT: begin
                issue                          = enable && !page_end;
                target[PAGE_LSB-1:LINE_LSB]    = line_idx_next;
            end
            default: begin
                issue = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/apf_mask_sel.sv
// Module: apf_mask_sel
// Chooses the way-lock mask that travels with a prefetch. A fill from a
// restricted-prefix instruction uses the prefix mask, any other fill uses the
// auto-prefetch mask. Assumes both masks have the same width.
module apf_mask_sel #(
    parameter int unsigned WAYS = 16
) (
    input  logic            prefix,
    input  logic [WAYS-1:0] apf_lock,
    input  logic [WAYS-1:0] pfx_lock,
    output logic [WAYS-1:0] mask
);

    // Per-way selection between the two masks.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign mask[w] = prefix ? pfx_lock[w] : apf_lock[w];
    end

endmodule

// File: rtl/apf_out_buf.sv
// Module: apf_out_buf
// Single-entry output register with valid/ready. It loads when told to and
// empties when the consumer takes the entry. Space is offered whenever the
// entry is empty or leaving in this cycle. Assumes load is only raised when
// space is high.
module apf_out_buf #(
    parameter int unsigned DATA_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              space,
    output logic              valid,
    input  logic              ready,
    output logic [DATA_W-1:0] dout
);

    // Room exists when nothing waits or the waiting entry is taken now.
    assign space = !valid || ready;

    // Valid flag: set on load, cleared when taken, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // Payload: captured only on load, so it holds while the entry waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/apf_gen.sv
// Module: apf_gen (top)
// Auto-prefetch generator. On each accepted fill it runs the policy, selects
// the lock mask and, when a prefetch is wanted, loads the single-entry output
// register. The fill input is stalled while a prefetch waits and the consumer
// is not ready. Configuration is sampled only at fill acceptance.
module apf_gen
    import apf_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WAYS     = 16,
    parameter int unsigned LINE_LSB = APF_LINE_LSB_DEF,
    parameter int unsigned PAGE_LSB = APF_PAGE_LSB_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_prefix,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_mode,
    input  logic [WAYS-1:0]   cfg_apf_lock,
    input  logic [WAYS-1:0]   cfg_pfx_lock,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [WAYS-1:0]   pf_way_mask
);

    localparam int unsigned REQ_W = ADDR_W + WAYS;

    logic              want;
    logic [ADDR_W-1:0] next_addr;
    logic [WAYS-1:0]   next_mask;
    logic              accept;
    logic              space;
    logic [REQ_W-1:0]  req_in;
    logic [REQ_W-1:0]  req_out;

    // Policy decision for the presented fill.
    apf_policy #(
        .ADDR_W   (ADDR_W),
        .LINE_LSB (LINE_LSB),
        .PAGE_LSB (PAGE_LSB)
    ) u_policy (
        .enable    (cfg_enable),
        .mode      (cfg_mode),
        .fill_addr (fill_addr),
        .issue     (want),
        .target    (next_addr)
    );

    // Lock mask chosen by instruction type.
    apf_mask_sel #(
        .WAYS (WAYS)
    ) u_mask (
        .prefix   (fill_prefix),
        .apf_lock (cfg_apf_lock),
        .pfx_lock (cfg_pfx_lock),
        .mask     (next_mask)
    );

    // Handshake on the fill side: accept only when the output has room.
    always_comb begin
        fill_ready = space;
        accept     = fill_valid && space;
        req_in     = {next_addr, next_mask};
    end

    // Output register holding the pending request.
    apf_out_buf #(
        .DATA_W (REQ_W)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && want),
        .din   (req_in),
        .space (space),
        .valid (pf_valid),
        .ready (pf_ready),
        .dout  (req_out)
    );

    // Unpack the held request onto the output ports.
    assign pf_addr     = req_out[REQ_W-1:WAYS];
    assign pf_way_mask = req_out[WAYS-1:0];

endmodule

// File: rtl/apf_gen_chk.sv
// Module: apf_gen_chk
// Property checker for apf_gen, attached by bind. Observes ports only.
module apf_gen_chk #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WAYS     = 16,
    parameter int unsigned LINE_LSB = 5,
    parameter int unsigned PAGE_LSB = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_valid,
    input logic              fill_ready,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_prefix,
    input logic              cfg_enable,
    input logic [1:0]        cfg_mode,
    input logic [WAYS-1:0]   cfg_apf_lock,
    input logic [WAYS-1:0]   cfg_pfx_lock,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [WAYS-1:0]   pf_way_mask
);

    logic acc;
    assign acc = fill_valid && fill_ready;

    // R1: a disabled fill leaves the output empty next cycle.
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !cfg_enable |=> !pf_valid);

    // R3: pair mode always issues, with bit 5 inverted.
    assert_pair_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cfg_enable && cfg_mode == 2'b01
        |=> pf_valid && (pf_addr[LINE_LSB] != $past(fill_addr[LINE_LSB])));

    // R4: next-line modes stay silent at the last line of a page.
    assert_page_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cfg_mode[1] && (&fill_addr[PAGE_LSB-1:LINE_LSB]) |=> !pf_valid);

    // R5: offset bits zero and upper bits copied from the fill.
    assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pf_addr[LINE_LSB-1:0] == '0);
    assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !pf_valid || pf_addr[ADDR_W-1:PAGE_LSB] == $past(fill_addr[ADDR_W-1:PAGE_LSB]));

    // R6: mask follows the prefix flag sampled at acceptance.
    assert_mask_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !fill_prefix |=> !pf_valid || pf_way_mask == $past(cfg_apf_lock));
    assert_mask_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && fill_prefix |=> !pf_valid || pf_way_mask == $past(cfg_pfx_lock));

    // R7: a waiting request stays put.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr) && $stable(pf_way_mask));

    // R8: fill input stalls while a request waits.
    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |-> !fill_ready);
    assert_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_valid |-> fill_ready);

    // R10: state after a reset cycle.
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

endmodule

bind apf_gen apf_gen_chk #(
    .ADDR_W   (ADDR_W),
    .WAYS     (WAYS),
    .LINE_LSB (LINE_LSB),
    .PAGE_LSB (PAGE_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_valid   (fill_valid),
    .fill_ready   (fill_ready),
    .fill_addr    (fill_addr),
    .fill_prefix  (fill_prefix),
    .cfg_enable   (cfg_enable),
    .cfg_mode     (cfg_mode),
    .cfg_apf_lock (cfg_apf_lock),
    .cfg_pfx_lock (cfg_pfx_lock),
    .pf_valid     (pf_valid),
    .pf_ready     (pf_ready),
    .pf_addr      (pf_addr),
    .pf_way_mask  (pf_way_mask)
);

// File: tb/apf_gen_tb.sv
`timescale 1ns/1ps
module apf_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0;
    logic        fill_ready;
    logic [31:0] fill_addr = '0;
    logic        fill_prefix = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [15:0] cfg_apf_lock = '0;
    logic [15:0] cfg_pfx_lock = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_addr;
    logic [15:0] pf_way_mask;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    apf_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid   (fill_valid),
        .fill_ready   (fill_ready),
        .fill_addr    (fill_addr),
        .fill_prefix  (fill_prefix),
        .cfg_enable   (cfg_enable),
        .cfg_mode     (cfg_mode),
        .cfg_apf_lock (cfg_apf_lock),
        .cfg_pfx_lock (cfg_pfx_lock),
        .pf_valid     (pf_valid),
        .pf_ready     (pf_ready),
        .pf_addr      (pf_addr),
        .pf_way_mask  (pf_way_mask)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sample_addr(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0020;
            2: return 32'h1234_5FC7;
            3: return 32'h1234_5FE9;
            4: return 32'hFFFF_F7E0;
            default: return 32'hABCD_EFFF;
        endcase
    endfunction

    // Reference: prefetch wanted? (arithmetic on the line number)
    function automatic bit ref_issue(input bit en, input int m, input logic [31:0] a);
        int unsigned ln = a / 32;
        if (!en) return 1'b0;
        if (m == 0) return (ln % 2) == 0;
        if (m == 1) return 1'b1;
        return (ln % 128) != 127;
    endfunction

    function automatic logic [31:0] ref_addr(input int m, input logic [31:0] a);
        logic [31:0] ln = a / 32;
        if (m == 0) return (ln | 32'd1) * 32;
        if (m == 1) return ((ln % 2) == 0 ? ln + 1 : ln - 1) * 32;
        return (ln + 1) * 32;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pf_valid == 1'b0, "R10 pf_valid after reset", 32'(pf_valid), 32'd0);
        check(fill_ready == 1'b1, "R10 fill_ready after reset", 32'(fill_ready), 32'd1);
        rst_n = 1'b1;

        // Sweep of policy x enable x prefix x address class.
        for (int m = 0; m < 4; m++) begin
            for (int en = 0; en < 2; en++) begin
                for (int px = 0; px < 2; px++) begin
                    for (int k = 0; k < 6; k++) begin
                        bit          e_iss;
                        logic [31:0] e_adr;
                        string       tag;
                        @(negedge clk);
                        cfg_mode     = 2'(m);
                        cfg_enable   = 1'(en);
                        fill_prefix  = 1'(px);
                        cfg_apf_lock = 16'h1111 * 16'(k + 1);
                        cfg_pfx_lock = 16'hF00F ^ 16'(m * 7 + k);
                        fill_addr    = sample_addr(k);
                        fill_valid   = 1'b1;
                        e_iss = ref_issue(1'(en), m, fill_addr);
                        e_adr = ref_addr(m, fill_addr);
                        tag = (en == 0) ? "R1" : (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
                        check(fill_ready == 1'b1, "R8 ready when empty", 32'(fill_ready), 32'd1);
                        @(negedge clk);
                        fill_valid = 1'b0;
                        check(pf_valid == e_iss, {tag, " issue"}, 32'(pf_valid), 32'(e_iss));
                        if (e_iss) begin
                            check(pf_addr == e_adr, {tag, " address"}, pf_addr, e_adr);
                            check(pf_addr[4:0] == 5'd0 && pf_addr[31:12] == fill_addr[31:12],
                                  "R5 alignment/upper", pf_addr, e_adr);
                            check(pf_way_mask == (px ? cfg_pfx_lock : cfg_apf_lock), "R6 mask",
                                  32'(pf_way_mask), 32'(px ? cfg_pfx_lock : cfg_apf_lock));
                        end
                    end
                end
            end
        end

        // Stall, hold, config change, then same-cycle take and reload.
        @(negedge clk);
        pf_ready     = 1'b0;
        cfg_enable   = 1'b1;
        cfg_mode     = 2'b01;
        fill_prefix  = 1'b0;
        cfg_apf_lock = 16'h00F0;
        fill_addr    = 32'h4000_0040;
        fill_valid   = 1'b1;
        @(negedge clk);
        fill_addr    = 32'h4000_1000;
        cfg_mode     = 2'b10;
        cfg_apf_lock = 16'hFFFF;
        check(pf_valid == 1'b1, "R7 appears next cycle", 32'(pf_valid), 32'd1);
        check(fill_ready == 1'b0, "R8 stall while pending", 32'(fill_ready), 32'd0);
        repeat (3) @(negedge clk);
        check(pf_addr == 32'h4000_0060, "R9 address unchanged", pf_addr, 32'h4000_0060);
        check(pf_way_mask == 16'h00F0, "R9 mask unchanged", 32'(pf_way_mask), 32'h00F0);
        check(pf_valid == 1'b1 && fill_ready == 1'b0, "R7 held while not ready",
              32'({pf_valid, fill_ready}), 32'b10);
        pf_ready = 1'b1;
        #0.5;
        check(fill_ready == 1'b1, "R8 ready when taken", 32'(fill_ready), 32'd1);
        @(negedge clk);
        fill_valid = 1'b0;
        check(pf_valid == 1'b1, "R8 replacement valid", 32'(pf_valid), 32'd1);
        check(pf_addr == 32'h4000_1020, "R8 replacement address", pf_addr, 32'h4000_1020);
        check(pf_way_mask == 16'hFFFF, "R8 replacement mask", 32'(pf_way_mask), 32'hFFFF);
        @(negedge clk);
        check(pf_valid == 1'b0, "R7 drained", 32'(pf_valid), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule